// File: doc/BRIEF.md
# Host Mailbox Control, Enable and Status Registers

This block sits on the host bus side of a two-way mailbox that links an external host with an internal processor. It holds three 16-bit registers. The first carries a two-bit code that picks how much hold margin the host bus address and data paths receive. The second holds the interrupt enables. The third reports the state of both mailboxes. The mailbox storage and the delay cells sit outside this block. They reach it only as a level flag, a set strobe and the exported delay code.

The host selects the bank with a 4-bit bank select and a 2-bit register address. The bank matches only when the select equals 0001. Read data is combinational from the current select and address. Writes take effect on the rising clock edge while the write strobe is high. The incoming-mailbox empty flag is not stored: it is always the inverse of the filled flag that the internal side drives. The outgoing-mailbox filled flag is sticky. The internal side sets it, and only the host can clear it, by writing a one. A single registered interrupt line reports any enabled status condition.

Top module: `mbox_host_regs`

## Requirements
- R1: Read data is 0x0000 and writes change nothing when the bank select is not 0001 or the register address is 3.
- R2: Address 0 is the control register. Bits [1:0] are a read/write delay code (0 = 5 ns, 1 = 3 ns, 2 = 1 ns, 3 = 0 ns), bits [15:2] read as zero, and the register resets to 0x0000.
- R3: Address 1 is the interrupt-enable register. Bit 1 enables the incoming-empty condition and bit 0 enables the outgoing-filled condition. Bits [15:2] read as zero, and the register resets to 0x0000.
- R4: Status bit 1 (address 2) always reads as the inverse of the input `inFilled`, in the same cycle.
- R5: A high `outFillSet` at a clock edge sets status bit 0, and the bit then stays set until the host clears it.
- R6: A host write to address 2 with data bit 0 = 1 clears status bit 0. A write with data bit 0 = 0 leaves it unchanged, and the value written to bit 1 has no effect.
- R7: When `outFillSet` and a host clear of status bit 0 fall on the same edge, the bit ends up set.
- R8: After reset the status register reads 0x0002 while `inFilled` is 0.
- R9: `irq` is registered. After each edge it equals the OR, over bit positions 1 and 0, of enable AND status as they stood before that edge. It is 0 after reset.
- R10: The output `delayCode` always equals control bits [1:0] and changes only on a control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bankSel | input | 4 | Bank select; this bank answers to 0001 |
| regAddr | input | 2 | Register address within the bank |
| hostWr | input | 1 | Host write strobe |
| wrData | input | 16 | Host write data |
| rdData | output | 16 | Host read data for the current select and address |
| inFilled | input | 1 | Incoming mailbox filled, driven by the internal side |
| outFillSet | input | 1 | Internal side wrote the outgoing mailbox |
| delayCode | output | 2 | Hold-margin delay code for the delay cells |
| irq | output | 1 | Registered interrupt request |

## Verification
The outgoing-filled flag has two writers: the internal set strobe and the host write-one-to-clear. Both can act on the same edge. The bench drives `outFillSet` together with a host status write of 0x0001 in a single cycle, and expects the flag to read 1 afterwards. A behavioural model that applies the set after the clear is compared with the design on every cycle. The same cycle-level model also judges the one-edge lag between a status change and `irq`, including a status bit that rises while its enable is being written.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int DATA_W = 16;
  parameter int CODE_W = 2;
  parameter logic [3:0] BANK_ID = 4'b0001;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_INTE = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  // Strobes from decode to the register datapath
  typedef struct packed {
    logic rdCtrl;
    logic rdInte;
    logic rdStat;
    logic wrCtrl;
    logic wrInte;
    logic wrStat;
  } strobe_t;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
(
  input  logic [3:0] bankSel,
  input  logic [1:0] regAddr,
  input  logic       hostWr,
  output strobe_t    stb
);
  logic bankHit;

  always_comb begin
    bankHit = (bankSel == BANK_ID);
    stb = '0;
    if (bankHit) begin
      unique case (reg_addr_e'(regAddr))
        ADDR_CTRL: begin stb.rdCtrl = 1'b1; stb.wrCtrl = hostWr; end
        ADDR_INTE: begin stb.rdInte = 1'b1; stb.wrInte = hostWr; end
        ADDR_STAT: begin stb.rdStat = 1'b1; stb.wrStat = hostWr; end
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/mbox_regs_dp.sv
module mbox_regs_dp
  import mbox_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [DW-1:0] wrData,
  input  logic          inFilled,
  input  logic          outFillSet,
  output logic [DW-1:0] rdData,
  output logic [CW-1:0] delayCode,
  output logic          irq,
  output logic          outFull,
  output logic [1:0]    inteBits
);
  localparam int NSRC = 2;

  logic [CW-1:0]   ctrlQ;
  logic [NSRC-1:0] inteQ;
  logic            outFullQ;
  logic [NSRC-1:0] statusVec;
  logic [NSRC-1:0] hitVec;
  logic            irqQ;
  logic            clrReq;

  assign statusVec = {~inFilled, outFullQ};
  assign clrReq    = stb.wrStat & wrData[0];

  // Per-source gating
  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign hitVec[i] = inteQ[i] & statusVec[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      inteQ    <= '0;
      outFullQ <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      if (stb.wrCtrl) ctrlQ <= wrData[CW-1:0];
      if (stb.wrInte) inteQ <= wrData[NSRC-1:0];
      if (outFillSet)  outFullQ <= 1'b1;
      else if (clrReq) outFullQ <= 1'b0;
      irqQ <= |hitVec;
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdCtrl) rdData[CW-1:0]   = ctrlQ;
    if (stb.rdInte) rdData[NSRC-1:0] = inteQ;
    if (stb.rdStat) rdData[NSRC-1:0] = statusVec;
  end

  logic unusedHi;
  assign unusedHi = ^wrData[DW-1:CW];

  assign delayCode = ctrlQ;
  assign irq       = irqQ;
  assign outFull   = outFullQ;
  assign inteBits  = inteQ;
endmodule

// File: rtl/mbox_host_regs.sv
module mbox_host_regs
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        bankSel,
  input  logic [1:0]        regAddr,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              inFilled,
  input  logic              outFillSet,
  output logic [CODE_W-1:0] delayCode,
  output logic              irq
);
  strobe_t    stb;
  logic       outFull;
  logic [1:0] inteBits;

  mbox_decode u_dec (
    .bankSel (bankSel),
    .regAddr (regAddr),
    .hostWr  (hostWr),
    .stb     (stb)
  );

  mbox_regs_dp #(.DW(DATA_W), .CW(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .inFilled   (inFilled),
    .outFillSet (outFillSet),
    .rdData     (rdData),
    .delayCode  (delayCode),
    .irq        (irq),
    .outFull    (outFull),
    .inteBits   (inteBits)
  );
endmodule

// File: rtl/mbox_host_chk.sv
module mbox_host_chk
  import mbox_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        bankSel,
  input logic [1:0]        regAddr,
  input logic              hostWr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              inFilled,
  input logic              outFillSet,
  input logic [CODE_W-1:0] delayCode,
  input logic              irq,
  input logic              outFull,
  input logic [1:0]        inteBits
);
  logic inBank, clrReq, ctrlWr, cond;
  assign inBank = (bankSel == BANK_ID);
  assign clrReq = hostWr & inBank & (regAddr == 2'd2) & wrData[0];
  assign ctrlWr = hostWr & inBank & (regAddr == 2'd0);
  assign cond   = (inteBits[1] & ~inFilled) | (inteBits[0] & outFull);

  p_unsel_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!inBank || regAddr == 2'd3) |-> rdData == '0);
  p_empty_live_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inBank && regAddr == 2'd2) |-> rdData[1] == !inFilled);
  p_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    outFillSet |=> outFull);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outFull && !clrReq) |=> outFull);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !outFillSet) |=> !outFull);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!outFull && !outFillSet) |=> !outFull);
  p_irq_on_r9: assert property (@(posedge clk) disable iff (!rstN)
    cond |=> irq);
  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cond |=> !irq);
  p_delay_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(delayCode));
endmodule

bind mbox_host_regs mbox_host_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bankSel    (bankSel),
  .regAddr    (regAddr),
  .hostWr     (hostWr),
  .wrData     (wrData),
  .rdData     (rdData),
  .inFilled   (inFilled),
  .outFillSet (outFillSet),
  .delayCode  (delayCode),
  .irq        (irq),
  .outFull    (outFull),
  .inteBits   (inteBits)
);

// File: tb/tb_mbox_host_regs.sv
module tb_mbox_host_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [3:0]  bankSel = 4'd1;
  logic [1:0]  regAddr = 2'd2;
  logic        hostWr = 1'b0;
  logic [15:0] wrData = '0;
  logic        inFilled = 1'b0;
  logic        outFillSet = 1'b0;
  logic [15:0] rdData;
  logic [1:0]  delayCode;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference model state
  int mDelay = 0, mInte = 0, mOut = 0, mIrq = 0;

  always #10 clk = ~clk;

  mbox_host_regs dut (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .regAddr(regAddr),
    .hostWr(hostWr), .wrData(wrData), .rdData(rdData),
    .inFilled(inFilled), .outFillSet(outFillSet),
    .delayCode(delayCode), .irq(irq)
  );

  function automatic int modelRead();
    if (bankSel != 4'd1) return 0;
    case (regAddr)
      2'd0: return mDelay;
      2'd1: return mInte;
      2'd2: return ((inFilled ? 0 : 1) << 1) | mOut;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle model: all updates use values from before the edge
  always @(posedge clk) begin
    if (!rstN) begin
      mDelay = 0; mInte = 0; mOut = 0; mIrq = 0;
    end else begin
      int st, sel;
      st  = ((inFilled ? 0 : 1) << 1) | mOut;
      sel = (bankSel == 4'd1);
      mIrq = ((mInte & st) != 0) ? 1 : 0;
      if (hostWr && sel && regAddr == 2'd0) mDelay = wrData[1:0];
      if (hostWr && sel && regAddr == 2'd1) mInte = wrData[1:0];
      if (outFillSet) mOut = 1;
      else if (hostWr && sel && regAddr == 2'd2 && wrData[0]) mOut = 0;
    end
  end

  // Every-cycle comparison (R1 R2 R3 R4 R9 R10)
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R1/R4 model rdData", rdData, modelRead());
      chk("R10 model delayCode", delayCode, mDelay);
      chk("R9 model irq", irq, mIrq);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic hostWrite(logic [3:0] b, logic [1:0] a, logic [15:0] d);
    bankSel = b; regAddr = a; wrData = d; hostWr = 1'b1;
    tick();
    hostWr = 1'b0; wrData = '0;
  endtask

  task automatic readAt(logic [3:0] b, logic [1:0] a);
    bankSel = b; regAddr = a;
    @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    #1 rstN = 1'b0;
    @(negedge clk);
    chk("R8 reset status", rdData, 16'h0002);
    chk("R9 reset irq", irq, 0);
    chk("R10 reset delayCode", delayCode, 0);
    regAddr = 2'd0; #1;
    chk("R2 reset ctrl", rdData, 0);
    regAddr = 2'd1; #1;
    chk("R3 reset inte", rdData, 0);
    @(posedge clk); #2 rstN = 1'b1;
    tick();

    // R2/R10: each delay code, upper bits read zero
    for (int c = 0; c < 4; c++) begin
      hostWrite(4'd1, 2'd0, 16'(c));
      readAt(4'd1, 2'd0);
      chk("R2 ctrl code", rdData, c);
      chk("R10 delayCode", delayCode, c);
      tick();
    end
    hostWrite(4'd1, 2'd0, 16'hFFFC);
    readAt(4'd1, 2'd0);
    chk("R2 upper bits zero", rdData, 0);
    tick();
    hostWrite(4'd1, 2'd0, 16'h0002);

    // R3: enable register width
    hostWrite(4'd1, 2'd1, 16'hFFFF);
    readAt(4'd1, 2'd1);
    chk("R3 inte readback", rdData, 3);
    tick();
    hostWrite(4'd1, 2'd1, 16'h0000);

    // R4: empty flag tracks inFilled combinationally
    inFilled = 1'b1;
    readAt(4'd1, 2'd2);
    chk("R4 empty low", rdData, 0);
    tick();
    inFilled = 1'b0; #1;
    chk("R4 empty high", rdData, 2);

    // R5/R6: set, sticky, ignored writes, clear
    tick();
    outFillSet = 1'b1; tick(); outFillSet = 1'b0;
    readAt(4'd1, 2'd2);
    chk("R5 set", rdData, 3);
    tick(); tick();
    readAt(4'd1, 2'd2);
    chk("R5 sticky", rdData, 3);
    tick();
    hostWrite(4'd1, 2'd2, 16'h0000);
    readAt(4'd1, 2'd2);
    chk("R6 write zero no effect", rdData, 3);
    tick();
    hostWrite(4'd1, 2'd2, 16'hFFFE);
    inFilled = 1'b1;
    readAt(4'd1, 2'd2);
    chk("R6 bit1 write ignored", rdData, 1);
    tick();
    inFilled = 1'b0;
    hostWrite(4'd1, 2'd2, 16'h0001);
    readAt(4'd1, 2'd2);
    chk("R6 clear", rdData, 2);
    tick();

    // R7: set beats clear
    outFillSet = 1'b1;
    hostWrite(4'd1, 2'd2, 16'h0001);
    outFillSet = 1'b0;
    readAt(4'd1, 2'd2);
    chk("R7 set wins", rdData, 3);
    tick();
    hostWrite(4'd1, 2'd2, 16'h0001);

    // R9: interrupt gating and one-edge lag
    inFilled = 1'b1;
    hostWrite(4'd1, 2'd1, 16'h0001);
    outFillSet = 1'b1; tick(); outFillSet = 1'b0;
    @(negedge clk);
    chk("R9 irq lags one edge", irq, 0);
    tick(); @(negedge clk);
    chk("R9 filled irq", irq, 1);
    tick();
    hostWrite(4'd1, 2'd1, 16'h0000);
    tick(); @(negedge clk);
    chk("R9 masked by enable", irq, 0);
    tick();
    hostWrite(4'd1, 2'd2, 16'h0001);
    hostWrite(4'd1, 2'd1, 16'h0002);
    tick(); @(negedge clk);
    chk("R9 empty masked while filled", irq, 0);
    tick();
    inFilled = 1'b0;
    tick(); @(negedge clk);
    chk("R9 empty irq", irq, 1);
    tick();
    inFilled = 1'b1;
    tick(); @(negedge clk);
    chk("R9 empty irq drops", irq, 0);
    tick();
    // enable and status rising together
    inFilled = 1'b0;
    hostWrite(4'd1, 2'd1, 16'h0003);
    tick();

    // R1: other banks and address 3
    hostWrite(4'd2, 2'd0, 16'h0001);
    readAt(4'd2, 2'd0);
    chk("R1 other bank reads zero", rdData, 0);
    tick();
    readAt(4'd1, 2'd0);
    chk("R1 other bank write ignored", rdData, 2);
    tick();
    hostWrite(4'd1, 2'd3, 16'hFFFF);
    readAt(4'd1, 2'd3);
    chk("R1 address 3 reads zero", rdData, 0);
    tick();
    readAt(4'd1, 2'd1);
    chk("R1 address 3 write ignored", rdData, 3);
    tick();
    hostWrite(4'd0, 2'd2, 16'h0001);
    outFillSet = 1'b1; tick(); outFillSet = 1'b0;
    hostWrite(4'd3, 2'd2, 16'h0001);
    readAt(4'd1, 2'd2);
    chk("R1 foreign clear ignored", rdData, 3);
    tick(); tick();

    finishRun();
  end
endmodule